// File: doc/BRIEF.md
# Dual-Modulus Alternating Clock Divider

This block divides a fast reference clock down to a slower output clock. In single mode it produces one integer division ratio. In dual mode it runs the first ratio for a programmed number of output periods and then the second ratio for another programmed number, and it repeats that pattern indefinitely. The long-run output frequency therefore sits between the two integer rates: reference × (M1 + M2) / (N1·M1 + N2·M2). This lets a design build an accurate low-frequency timebase, such as 32.768 kHz, from a reference that is not an integer multiple of it.

All four programming fields are written as their real value minus one. Mode and field changes are sampled only on the last reference cycle of an output period. A running period is never cut short or lengthened. A strobe marks the first reference cycle of each output period, and a status output shows which of the two ratios is driving the current period.

Top module: `dualmod_clkdiv`

## Requirements
- R1: With `dual_en` low, every output period uses ratio A: it lasts `ratio_a`+1 reference cycles and `phase_b` stays 0.
- R2: With `dual_en` high, the output produces `count_a`+1 periods at ratio A, then `count_b`+1 periods at ratio B, and then the pattern repeats.
- R3: `phase_b` is 1 exactly during periods driven by ratio B and 0 during periods driven by ratio A. It changes only on a cycle where `period_start` is 1.
- R4: Each field encodes its real value minus one. A ratio field of 0 gives a period of one reference cycle, and a count field of 0 gives one period per phase.
- R5: Over one full dual-mode pattern, (M1+M2) output periods span exactly N1·M1 + N2·M2 reference cycles, where N and M are the real values (field + 1).
- R6: Within a period of N reference cycles, `div_clk` is 1 for the first max(1, floor(N/2)) cycles and 0 for the remaining cycles.
- R7: `period_start` is 1 on the first reference cycle of every output period and 0 on every other cycle.
- R8: Reset is synchronous and active low. On the first cycle after reset is released, a fresh ratio-A period begins: `period_start`=1, `div_clk`=1, `phase_b`=0, and the repeat count is cleared.
- R9: A change to any field or to `dual_en` that arrives during a period does not alter that period's length. The change is sampled on the period's last reference cycle.
- R10: If `dual_en` is cleared while ratio B is active, the next period runs at ratio A and `phase_b` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_en | input | 1 | 1 = alternate ratios A and B; 0 = ratio A only |
| ratio_a | input | 12 | Ratio A, real value minus one |
| count_a | input | 12 | Number of periods at ratio A, minus one |
| ratio_b | input | 12 | Ratio B, real value minus one |
| count_b | input | 12 | Number of periods at ratio B, minus one |
| div_clk | output | 1 | Divided clock (registered) |
| period_start | output | 1 | High on the first reference cycle of each output period |
| phase_b | output | 1 | 1 while ratio B drives the current period |

## Verification
On every cycle, the assertions check the following:
- the position counter stays inside the current ratio;
- the ratio held for a period changes only at a period boundary;
- `div_clk` rises only on a strobe cycle, and the strobe always coincides with a high level;
- `phase_b` moves only at a period start;
- single mode forces phase A after the boundary;
- the repeat count clears whenever the phase switches.

Only the bench scenarios can show the rest. These include the exact A/B period pattern, the cycle total of a full dual sequence, reprogramming in the middle of a period without disturbing it, leaving dual mode while ratio B is active, and the one-cycle-ratio extreme. The bench checks these against a cycle model built from the requirements.

// File: rtl/dmd_pkg.sv
// Shared definitions for the dual-modulus divider.
// Assumes nothing beyond a two-phase selection.
package dmd_pkg;

    // Which of the two ratios drives the current output period.
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

endpackage

// File: rtl/dmd_period_timer.sv
// Period timer: counts reference cycles inside one output period,
// holds the ratio of that period, and produces the registered divided
// clock and start strobe.
// Assumes load_ratio is meaningful on the cycle where last is high; it is
// only sampled then, so the held ratio never changes mid-period.
module dmd_period_timer #(
    parameter int unsigned FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] init_ratio,
    input  logic [FW-1:0] load_ratio,
    output logic          last,
    output logic          div_out,
    output logic          start_out
);
    localparam int unsigned CW = FW + 1;

    logic [FW-1:0] cnt_q;
    logic [FW-1:0] cnt_d;
    logic [FW-1:0] ratio_q;
    logic [FW-1:0] ratio_d;
    logic          div_q;
    logic          start_q;

    // High-time length for a ratio field: max(1, floor((field+1)/2)).
    function automatic logic [CW-1:0] high_len(input logic [FW-1:0] f);
        logic [CW-1:0] n;
        n = (CW'(f) + CW'(1)) >> 1;
        if (n == '0) n = CW'(1);
        return n;
    endfunction

    // Last reference cycle of the current period.
    assign last = (cnt_q == ratio_q);

    // Next count and next held ratio.
    always_comb begin
        cnt_d   = last ? '0 : cnt_q + FW'(1);
        ratio_d = last ? load_ratio : ratio_q;
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= init_ratio;
            div_q   <= 1'b1;
            start_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            div_q   <= (CW'(cnt_d) < high_len(ratio_d));
            start_q <= last;
        end
    end

    assign div_out   = div_q;
    assign start_out = start_q;

    // Position never passes the held ratio.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ratio_q);

    // Held ratio changes only at a period boundary.
    assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |-> $stable(ratio_q));

    // Divided clock rises only on the first cycle of a period.
    assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> start_q);

    // First cycle of every period is high.
    assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> div_q);

endmodule

// File: rtl/dmd_phase_seq.sv
// Phase sequencer: counts completed periods in the active phase and
// decides, at each period end, whether the next period uses ratio A or B.
// Assumes adv is high for exactly one cycle per period (its last cycle).
module dmd_phase_seq
    import dmd_pkg::*;
#(
    parameter int unsigned FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          dual_en,
    input  logic [FW-1:0] reps_a,
    input  logic [FW-1:0] reps_b,
    output phase_e        phase,
    output phase_e        phase_nxt
);
    phase_e        phase_q;
    logic [FW-1:0] rep_q;
    logic [FW-1:0] rep_d;

    // Next phase and repeat count at a period end.
    always_comb begin
        phase_nxt = phase_q;
        rep_d     = rep_q;
        if (adv) begin
            if (!dual_en) begin
                phase_nxt = PH_A;
                rep_d     = '0;
            end else if (phase_q == PH_A) begin
                if (rep_q >= reps_a) begin
                    phase_nxt = PH_B;
                    rep_d     = '0;
                end else begin
                    rep_d = rep_q + FW'(1);
                end
            end else begin
                if (rep_q >= reps_b) begin
                    phase_nxt = PH_A;
                    rep_d     = '0;
                end else begin
                    rep_d = rep_q + FW'(1);
                end
            end
        end
    end

    // Phase and repeat registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_A;
            rep_q   <= '0;
        end else begin
            phase_q <= phase_nxt;
            rep_q   <= rep_d;
        end
    end

    assign phase = phase_q;

    // Single mode always returns to ratio A after a boundary.
    assert_single_to_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !dual_en) |=> (phase_q == PH_A));

    // Repeat count restarts whenever the phase switches.
    assert_rep_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (phase_nxt != phase_q)) |=> (rep_q == '0));

endmodule

// File: rtl/dualmod_clkdiv.sv
// Dual-modulus alternating clock divider top.
// Joins the period timer and phase sequencer; picks which ratio field
// feeds the next period. Assumes fields are stable around the last
// cycle of a period if a defined switch-over point is wanted.
module dualmod_clkdiv
    import dmd_pkg::*;
#(
    parameter int unsigned FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_en,
    input  logic [FW-1:0] ratio_a,
    input  logic [FW-1:0] count_a,
    input  logic [FW-1:0] ratio_b,
    input  logic [FW-1:0] count_b,
    output logic          div_clk,
    output logic          period_start,
    output logic          phase_b
);
    logic          last;
    phase_e        phase;
    phase_e        phase_nxt;
    logic [FW-1:0] next_ratio;

    // Ratio loaded for the next period follows the next phase.
    always_comb begin
        next_ratio = (phase_nxt == PH_B) ? ratio_b : ratio_a;
    end

    dmd_period_timer #(.FW(FW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_ratio (ratio_a),
        .load_ratio (next_ratio),
        .last       (last),
        .div_out    (div_clk),
        .start_out  (period_start)
    );

    dmd_phase_seq #(.FW(FW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (last),
        .dual_en   (dual_en),
        .reps_a    (count_a),
        .reps_b    (count_b),
        .phase     (phase),
        .phase_nxt (phase_nxt)
    );

    assign phase_b = (phase == PH_B);

    // Phase indicator only moves on the first cycle of a period.
    assert_phase_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> $stable(phase_b));

endmodule

// File: tb/sim_dualmod_clkdiv.sv
`timescale 1ns/1ps
module sim_dualmod_clkdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_en = 1'b0;
    logic [11:0] ratio_a = '0, count_a = '0, ratio_b = '0, count_b = '0;
    logic        div_clk, period_start, phase_b;

    always #2.5 clk = ~clk;

    dualmod_clkdiv u0 (
        .clk(clk), .rst_n(rst_n), .dual_en(dual_en),
        .ratio_a(ratio_a), .count_a(count_a), .ratio_b(ratio_b), .count_b(count_b),
        .div_clk(div_clk), .period_start(period_start), .phase_b(phase_b)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  chk_on = 0;
    bit  done = 0;

    // Reference model state (real values, not fields).
    int  m_cnt, m_n, m_rep;
    bit  m_ph;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int hi_len(input int n);
        int h;
        h = n / 2;
        if (h < 1) h = 1;
        return h;
    endfunction

    // Model update from the requirements, on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_n = int'(ratio_a) + 1; m_ph = 0; m_rep = 0;
        end else if (m_cnt == m_n - 1) begin
            m_cnt = 0;
            if (!dual_en) begin
                m_ph = 0; m_rep = 0;
            end else if (m_rep >= (m_ph ? int'(count_b) : int'(count_a))) begin
                m_ph = ~m_ph; m_rep = 0;
            end else begin
                m_rep++;
            end
            m_n = (m_ph ? int'(ratio_b) : int'(ratio_a)) + 1;
        end else begin
            m_cnt++;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(div_clk == (m_cnt < hi_len(m_n)), "R6 div_clk", div_clk, m_cnt < hi_len(m_n));
            check(period_start == (m_cnt == 0), "R7 period_start", period_start, m_cnt == 0);
            check(phase_b == m_ph, "R2/R3 phase_b", phase_b, m_ph);
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Count cycles from the current start to the next start.
    task automatic gap_to_start(output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (!period_start);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int g, starts, cyc;
        void'($urandom(32'd2024));
        @(posedge clk); chk_on = 1;

        // R8: reset state, single mode ratio 8.
        ratio_a = 12'd7;
        do_reset();
        check(period_start && div_clk && !phase_b, "R8 first cycle after reset",
              {period_start, div_clk, phase_b}, 3'b110);

        // R1 and R9: period is 8; a change mid-period applies next period.
        @(negedge clk); @(negedge clk);
        ratio_a = 12'd1;
        gap_to_start(g);
        check(g == 6, "R9 remaining cycles of running period", g, 6);
        gap_to_start(g);
        check(g == 2, "R1 new single ratio after boundary", g, 2);

        // R4: ratio field 0 gives a start and high level every cycle.
        ratio_a = 12'd0;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            check(period_start && div_clk, "R4 one-cycle period", {period_start, div_clk}, 2'b11);
            @(negedge clk);
        end

        // R5 and R2: full dual sequence N1=5 M1=3, N2=6 M2=2 -> 27 cycles.
        dual_en = 1'b1; ratio_a = 12'd4; count_a = 12'd2; ratio_b = 12'd5; count_b = 12'd1;
        do_reset();
        starts = 0; cyc = 0;
        while (starts < 6) begin
            if (period_start) starts++;
            cyc++;
            if (starts == 4 && period_start) check(phase_b == 1'b1, "R2 fourth period at B", phase_b, 1);
            if (starts < 6) @(negedge clk);
        end
        check(cyc - 1 == 27, "R5 cycles per dual sequence", cyc - 1, 27);

        // R10: leave dual mode while B is active.
        while (!phase_b) @(negedge clk);
        dual_en = 1'b0;
        gap_to_start(g);
        check(phase_b == 1'b0, "R10 return to ratio A", phase_b, 0);

        // Large ratio corner.
        ratio_a = 12'd4095;
        do_reset();
        gap_to_start(g);
        check(g == 4096, "R1 maximum ratio period", g, 4096);

        // Constrained random episodes.
        for (int ep = 0; ep < 60; ep++) begin
            int len, chg;
            dual_en = 1'($urandom_range(1, 0));
            ratio_a = 12'($urandom_range(15, 0));
            ratio_b = 12'($urandom_range(15, 0));
            count_a = 12'($urandom_range(5, 0));
            count_b = 12'($urandom_range(5, 0));
            if ($urandom_range(4, 0) == 0) do_reset();
            len = $urandom_range(300, 60);
            chg = $urandom_range(len - 1, 0);
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                if (c == chg) begin
                    ratio_a = 12'($urandom_range(15, 0));
                    count_b = 12'($urandom_range(5, 0));
                    dual_en = 1'($urandom_range(1, 0));
                end
            end
        end

        @(negedge clk);
        finish_run();
    end
endmodule